// File: doc/BRIEF.md
# Packet-Count Stream Split Switch

This block is a one-input, two-output switch element for a multistage shuffle-exchange network built on a chip. Routing is not decided for each data word from its own address. A status header arrives on a separate header stream instead. It names one of two outputs and gives a packet count. The switch then steers exactly that many words from its input data stream to the chosen output, and after that it returns to wait for the next header.

Each header carries three flag bits (head, live and tail), a one-bit destination and a packet count. A header with the live and tail flags both set ends the whole stream. The switch then enters a terminal state, where it accepts nothing and drives nothing, and only reset brings it out. A header with tail set and live clear only closes the current transfer. It is consumed and the switch keeps waiting.

Every stream uses a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. While a burst is running, the input's ready is the selected output's ready, passed through combinationally. Back-pressure from that output therefore stalls the input word by word, with no buffering inside the switch. The header stream is held off while a burst is in progress.

Top module: `stream_split_switch`

## Requirements
- R1: After reset, and until a header is accepted, `hdr_ready` is 1 and `in_ready`, `out0_valid` and `out1_valid` are all 0.
- R2: A header with head=1, live=1, tail=0, dst=0 and a count N>0 is accepted when `hdr_valid` and `hdr_ready` are both high. The next N input words then appear on output 0.
- R3: The same header with dst=1 sends the next N input words to output 1.
- R4: After the N-th word of a burst has transferred, the switch is idle again in the next cycle (`hdr_ready`=1, `in_ready`=0). No further input word is taken until a new burst header arrives.
- R5: During a burst, `in_ready` equals the selected output's ready. A word moves only in a cycle where `in_valid` and that ready are both 1. Stalled cycles do not use up the count.
- R6: A burst header with count 0 is consumed, and the switch stays idle without moving any data.
- R7: A header with live=1 and tail=1 is consumed, and the switch enters a terminal state. In that state `hdr_ready`, `in_ready`, `out0_valid` and `out1_valid` stay 0 until reset.
- R8: A header with live=0 and tail=1 (end of the current transfer) is consumed, and the switch stays idle and ready for further headers.
- R9: Any other flag combination with tail=0 that is not head=1/live=1 is consumed and ignored. The switch stays idle and moves no data.
- R10: `hdr_ready` is 0 for as long as a burst is in progress, so a waiting header is taken only after the burst's last word.
- R11: At most one output's valid is high in any cycle, the unselected output's valid is 0, and the forwarded word equals `in_data`.
- R12: Reset leaves the terminal state and restores the behaviour of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header stream valid |
| hdr_ready | output | 1 | Header stream ready (high only when idle) |
| hdr_head | input | 1 | Header flag: start of burst |
| hdr_live | input | 1 | Header flag: stream valid |
| hdr_tail | input | 1 | Header flag: end marker |
| hdr_dst | input | 1 | Destination output, 0 or 1 |
| hdr_count | input | CNT_W | Number of data words in the burst |
| in_valid | input | 1 | Input data valid |
| in_ready | output | 1 | Input data ready |
| in_data | input | DATA_W | Input data word |
| out0_valid | output | 1 | Output 0 valid |
| out0_ready | input | 1 | Output 0 ready |
| out0_data | output | DATA_W | Output 0 data |
| out1_valid | output | 1 | Output 1 valid |
| out1_ready | input | 1 | Output 1 ready |
| out1_data | output | DATA_W | Output 1 data |

## Verification
Assertions check the following on every cycle. A burst counter never decrements at zero and never loads while it is counting. At most one output is valid. An output handshake always coincides with an input handshake. The terminal state is sticky and silent. An accepted burst header lands in the forwarding state its destination names. The rest can only be shown by the bench's scenarios: the exact number of words per burst, the return to idle right after the last word, and the handling of zero counts, end-of-transfer markers and junk flag combinations. Two more need scenarios too: a second header queued behind a running burst, and random back-pressure on both outputs. The bench's behavioural model compares all of this on every clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NUM_OUT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD0 = 2'd1,
    ST_FWD1 = 2'd2,
    ST_DONE = 2'd3
  } sw_state_e;

  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_BURST = 2'd1,
    ACT_HALT  = 2'd2
  } hdr_act_e;
endpackage

// File: rtl/sw_hdr_decode.sv
module sw_hdr_decode
  import sw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             head,
  input  logic             live,
  input  logic             tail,
  input  logic [CNT_W-1:0] count,
  output hdr_act_e         act
);
  logic is_start;
  logic is_end;
  logic has_words;

  assign is_start  = head && live && !tail;
  assign is_end    = live && tail;
  assign has_words = (count != '0);

  always_comb begin
    if (is_end) begin
      act = ACT_HALT;
    end else if (is_start && has_words) begin
      act = ACT_BURST;
    end else begin
      act = ACT_DROP;
    end
  end
endmodule

// File: rtl/sw_burst_ctr.sv
module sw_burst_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last,
  output logic             empty
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec) begin
      remain <= remain - 1'b1;
    end
  end

  assign last  = (remain == {{(CNT_W-1){1'b0}}, 1'b1});
  assign empty = (remain == '0);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty)
    else $error("burst counter decremented at zero");

  assert_no_reload_midburst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty)
    else $error("burst counter reloaded while counting");
endmodule

// File: rtl/sw_out_steer.sv
module sw_out_steer #(
  parameter int DATA_W  = 32,
  parameter int NUM_OUT = 2,
  localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               fwd_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  input  logic [NUM_OUT-1:0] out_ready,
  output logic [NUM_OUT-1:0] out_valid,
  output logic [DATA_W-1:0]  out_data [NUM_OUT],
  output logic [NUM_OUT-1:0] out_fire
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_port
    logic chosen;
    assign chosen       = fwd_en && (sel == SEL_W'(k));
    assign out_valid[k] = chosen && in_valid;
    assign out_data[k]  = in_data;
    assign out_fire[k]  = out_valid[k] && out_ready[k];
  end

  assign in_ready = fwd_en && out_ready[sel];
endmodule

// File: rtl/stream_split_switch.sv
module stream_split_switch
  import sw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic              hdr_head,
  input  logic              hdr_live,
  input  logic              hdr_tail,
  input  logic              hdr_dst,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out0_valid,
  input  logic              out0_ready,
  output logic [DATA_W-1:0] out0_data,
  output logic              out1_valid,
  input  logic              out1_ready,
  output logic [DATA_W-1:0] out1_data
);
  localparam int SEL_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  sw_state_e          state, state_nx;
  hdr_act_e           act;
  logic               hdr_fire;
  logic               fwd_en;
  logic [SEL_W-1:0]   route;
  logic [NUM_OUT-1:0] o_ready, o_valid, o_fire;
  logic [DATA_W-1:0]  o_data [NUM_OUT];
  logic [NUM_OUT-1:0] ctr_load, ctr_last, ctr_empty;

  sw_hdr_decode #(.CNT_W(CNT_W)) u_dec (
    .head  (hdr_head),
    .live  (hdr_live),
    .tail  (hdr_tail),
    .count (hdr_count),
    .act   (act)
  );

  assign hdr_ready = (state == ST_IDLE);
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign fwd_en    = (state == ST_FWD0) || (state == ST_FWD1);
  assign route     = SEL_W'(state == ST_FWD1);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_ctr
    assign ctr_load[k] = hdr_fire && (act == ACT_BURST) && (SEL_W'(hdr_dst) == SEL_W'(k));
    sw_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load[k]),
      .load_val (hdr_count),
      .dec      (o_fire[k]),
      .last     (ctr_last[k]),
      .empty    (ctr_empty[k])
    );
  end

  assign o_ready = {out1_ready, out0_ready};

  sw_out_steer #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_steer (
    .fwd_en    (fwd_en),
    .sel       (route),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_ready (o_ready),
    .out_valid (o_valid),
    .out_data  (o_data),
    .out_fire  (o_fire)
  );

  assign out0_valid = o_valid[0];
  assign out1_valid = o_valid[1];
  assign out0_data  = o_data[0];
  assign out1_data  = o_data[1];

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (hdr_fire) begin
          if (act == ACT_HALT) begin
            state_nx = ST_DONE;
          end else if (act == ACT_BURST) begin
            state_nx = hdr_dst ? ST_FWD1 : ST_FWD0;
          end
        end
      end
      ST_FWD0: if (o_fire[0] && ctr_last[0]) state_nx = ST_IDLE;
      ST_FWD1: if (o_fire[1] && ctr_last[1]) state_nx = ST_IDLE;
      ST_DONE: state_nx = ST_DONE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nx;
    end
  end

  assert_one_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out1_valid, out0_valid}))
    else $error("both outputs valid");

  assert_out0_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_valid && out0_ready) |-> (in_valid && in_ready))
    else $error("output 0 moved without input handshake");

  assert_out1_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out1_valid && out1_ready) |-> (in_valid && in_ready))
    else $error("output 1 moved without input handshake");

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_DONE))
    else $error("terminal state left without reset");

  assert_done_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (!hdr_ready && !in_ready && !out0_valid && !out1_valid))
    else $error("terminal state not silent");

  assert_burst_dst0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && hdr_head && hdr_live && !hdr_tail && !hdr_dst && hdr_count != '0)
    |=> (state == ST_FWD0))
    else $error("dst 0 burst did not start");

  assert_burst_dst1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && hdr_head && hdr_live && !hdr_tail && hdr_dst && hdr_count != '0)
    |=> (state == ST_FWD1))
    else $error("dst 1 burst did not start");

  assert_fwd_counter_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWD0) |-> !ctr_empty[0])
    else $error("forwarding on output 0 with empty count");
endmodule

// File: tb/sim_stream_split_switch.sv
module sim_stream_split_switch;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hdr_valid = 1'b0, hdr_head = 1'b0, hdr_live = 1'b0;
  logic              hdr_tail = 1'b0, hdr_dst = 1'b0;
  logic [CNT_W-1:0]  hdr_count = '0;
  logic              hdr_ready;
  logic              in_valid = 1'b0, in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out0_valid, out1_valid;
  logic              out0_ready = 1'b1, out1_ready = 1'b1;
  logic [DATA_W-1:0] out0_data, out1_data;

  int n_checks = 0;
  int n_fail   = 0;
  int m_mode   = 0;   // 0 idle, 1 to out0, 2 to out1, 3 terminal
  int m_rem    = 0;
  int rx0 = 0, rx1 = 0;
  int ready_mode = 0;
  logic [7:0]  lfsr = 8'hA5;
  logic [31:0] seq = 32'h1000;

  always #5 clk = ~clk;

  stream_split_switch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_head(hdr_head),
    .hdr_live(hdr_live), .hdr_tail(hdr_tail), .hdr_dst(hdr_dst), .hdr_count(hdr_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_data(out0_data),
    .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_data(out1_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // behavioural reference: advances on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0;
      m_rem  = 0;
    end else begin
      case (m_mode)
        0: if (hdr_valid) begin
             if (hdr_live && hdr_tail) m_mode = 3;
             else if (hdr_head && hdr_live && !hdr_tail && hdr_count != 0) begin
               m_mode = hdr_dst ? 2 : 1;
               m_rem  = int'(hdr_count);
             end
           end
        1, 2: if (in_valid && (m_mode == 1 ? out0_ready : out1_ready)) begin
             m_rem--;
             if (m_rem == 0) m_mode = 0;
           end
        default: ;
      endcase
    end
  end

  // per-cycle comparison, 1 ns before the rising edge
  initial forever begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      string tg;
      bit e_hr, e_ir, e_v0, e_v1;
      tg   = (m_mode == 3) ? "R7" : (m_mode == 0) ? "R1" : "R5";
      e_hr = (m_mode == 0);
      e_ir = (m_mode == 1) ? out0_ready : (m_mode == 2) ? out1_ready : 1'b0;
      e_v0 = (m_mode == 1) && in_valid;
      e_v1 = (m_mode == 2) && in_valid;
      chk(hdr_ready == e_hr, (m_mode == 0) ? "R4" : "R10", hdr_ready, e_hr);
      chk(in_ready == e_ir, tg, in_ready, e_ir);
      chk(out0_valid == e_v0 && out1_valid == e_v1, "R11",
          {out1_valid, out0_valid}, {e_v1, e_v0});
      if (out0_valid) chk(out0_data == in_data, "R11", out0_data, in_data);
      if (out1_valid) chk(out1_data == in_data, "R11", out1_data, in_data);
      if (out0_valid && out0_ready) rx0++;
      if (out1_valid && out1_ready) rx1++;
    end
  end

  // output ready pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out0_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
    out1_ready = (ready_mode == 0) ? 1'b1 : lfsr[3];
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // entered and left at a falling edge
  task automatic send_hdr(input bit h, input bit l, input bit t, input bit d, input int cnt);
    bit ok;
    hdr_head = h; hdr_live = l; hdr_tail = t; hdr_dst = d;
    hdr_count = CNT_W'(cnt);
    hdr_valid = 1'b1;
    while (1) begin
      #4;
      ok = hdr_ready;
      @(negedge clk);
      if (ok) break;
    end
    hdr_valid = 1'b0;
  endtask

  task automatic send_data(input int n, input bit gaps);
    bit ok;
    for (int i = 0; i < n; i++) begin
      if (gaps && lfsr[6]) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = seq;
      while (1) begin
        #4;
        ok = in_ready;
        @(negedge clk);
        if (ok) break;
      end
      seq++;
    end
    in_valid = 1'b0;
  endtask

  task automatic stray_data(input int n, input string tag);
    in_valid = 1'b1;
    in_data  = 32'hDEAD_0000;
    for (int i = 0; i < n; i++) begin
      #4;
      chk(!in_ready && !out0_valid && !out1_valid, tag, in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(hdr_ready && !in_ready && !out0_valid && !out1_valid, "R1",
        {hdr_ready, in_ready, out0_valid, out1_valid}, 4'b1000);
    @(negedge clk);

    // R2: burst of 5 to output 0
    rx0 = 0; rx1 = 0;
    send_hdr(1, 1, 0, 0, 5);
    send_data(5, 0);
    chk(rx0 == 5 && rx1 == 0, "R2", rx0, 5);
    stray_data(2, "R4");

    // R3 / R5: burst of 7 to output 1 under back-pressure and gaps
    ready_mode = 1;
    rx0 = 0; rx1 = 0;
    send_hdr(1, 1, 0, 1, 7);
    send_data(7, 1);
    chk(rx1 == 7 && rx0 == 0, "R3", rx1, 7);

    // R5: back-pressure on output 0
    rx0 = 0;
    send_hdr(1, 1, 0, 0, 9);
    send_data(9, 1);
    chk(rx0 == 9, "R5", rx0, 9);

    // R10: second header waits behind a running burst
    rx0 = 0; rx1 = 0;
    send_hdr(1, 1, 0, 0, 3);
    fork
      send_hdr(1, 1, 0, 1, 2);
      send_data(3, 0);
    join
    chk(rx0 == 3 && rx1 == 0, "R10", rx1, 0);
    send_data(2, 0);
    chk(rx1 == 2, "R10", rx1, 2);
    ready_mode = 0;

    // R6: zero count
    send_hdr(1, 1, 0, 1, 0);
    stray_data(3, "R6");

    // R8: end-of-transfer marker, then a normal burst
    send_hdr(0, 0, 1, 0, 4);
    #4;
    chk(hdr_ready, "R8", hdr_ready, 1);
    @(negedge clk);
    stray_data(1, "R8");
    rx1 = 0;
    send_hdr(1, 1, 0, 1, 1);
    send_data(1, 0);
    chk(rx1 == 1, "R8", rx1, 1);

    // R9: junk flag combinations
    send_hdr(0, 1, 0, 0, 3);
    stray_data(2, "R9");
    send_hdr(1, 0, 0, 1, 3);
    stray_data(2, "R9");

    // R7: end of stream, then everything held off
    send_hdr(0, 1, 1, 0, 0);
    hdr_valid = 1'b1; hdr_head = 1'b1; hdr_live = 1'b1; hdr_tail = 1'b0; hdr_count = 8'd2;
    in_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #4;
      chk(!hdr_ready && !in_ready && !out0_valid && !out1_valid, "R7",
          {hdr_ready, in_ready, out0_valid, out1_valid}, 0);
      @(negedge clk);
    end
    hdr_valid = 1'b0;
    in_valid  = 1'b0;

    // R12: reset leaves the terminal state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(hdr_ready && !in_ready, "R12", {hdr_ready, in_ready}, 2'b10);
    @(negedge clk);
    rx0 = 0;
    send_hdr(1, 1, 0, 0, 255);
    send_data(255, 0);
    chk(rx0 == 255, "R12", rx0, 255);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule